// File: doc/BRIEF.md
# Page Permission Indirection Unit

This unit turns the attribute bits of a translation descriptor into effective read, write and execute rights by looking them up in a table that software programs. Four scattered descriptor bits form a 4-bit index. That index picks one of sixteen 4-bit permission codes, and the code is decoded into access flags. There are two tables. One serves privileged accesses and the other serves unprivileged accesses, and a privilege flag sent with each request selects between them.

Software loads the two tables and a control word through a single-cycle write port made of a strobe, an address and 64-bit data. Indirection is used only while the enable bit in the control word is set. While it is clear, the unit grants nothing and raises a bypass flag so that a conventional fixed decoder can supply the rights. Each lookup returns its result one clock after the request. The result carries a valid flag, the read, write and execute rights, and flags that mark overlay-class codes, guarded-stack pages and reserved codes.

Top module: `perm_indir_unit`

## Requirements
- R1: After reset both tables hold zero and indirection is disabled, so a lookup reports bypass. Once indirection is enabled, a lookup against a table still at reset returns code 0x0: overlay set, no rights.
- R2: The lookup index is {desc[54], desc[53], desc[51], desc[6]} (index bit 3 down to bit 0). No other descriptor bit affects the result.
- R3: Entry N of a table is data bits 4N+3..4N. A request with req_priv=1 reads the privileged table and one with req_priv=0 reads the unprivileged table.
- R4: Code 0x8 gives R, 0xa gives RX, 0xc gives RW and 0xe gives RWX. All four have overlay, guarded and reserved clear.
- R5: Code 0x9 raises rsp_gcs and gives no read, write or execute.
- R6: Codes 0x0, 0x1, 0x2, 0x3, 0x5, 0x6 and 0x7 raise rsp_overlay and give none, R, X, RX, RW, RW and RWX respectively.
- R7: Codes 0x4, 0xb, 0xd and 0xf raise rsp_reserved and give no rights.
- R8: While control bit 1 is clear, every lookup returns no rights, rsp_bypass=1 and all other flags clear. The other control bits have no effect.
- R9: A write takes effect at the clock edge that accepts it. A lookup in that same cycle sees the old table contents.
- R10: rsp_valid is high exactly in the cycle after a cycle with req_valid high. The result outputs hold their values while no request arrives.
- R11: Write address 0 loads the unprivileged table, 1 loads the privileged table and 2 loads the control word. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 2 | Write address: 0 unprivileged table, 1 privileged table, 2 control |
| cfg_wdata | input | 64 | Write data |
| req_valid | input | 1 | Lookup request valid |
| req_desc | input | 64 | Translation descriptor |
| req_priv | input | 1 | 1 = privileged access |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_read | output | 1 | Read permitted |
| rsp_write | output | 1 | Write permitted |
| rsp_exec | output | 1 | Execute permitted |
| rsp_overlay | output | 1 | Code belongs to the overlay class |
| rsp_gcs | output | 1 | Guarded control stack page |
| rsp_reserved | output | 1 | Reserved code was fetched |
| rsp_bypass | output | 1 | Indirection disabled; legacy decode applies |

## Verification
The assertions assume that reset is applied before the first request and that req_valid is never unknown while reset is released. The bench drives every input at the falling edge only, holds req_valid at a defined level from time zero and keeps cfg_addr within its two bits. The checks that tie rsp_bypass to the enable assume that a control write and a lookup never fall in the same cycle. The bench applies control writes only in cycles that carry no lookup.

// File: rtl/perm_indir_pkg.sv
package perm_indir_pkg;
  localparam int unsigned DESC_W     = 64;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned IDX_W      = 4;
  localparam int unsigned N_ENTRIES  = 1 << IDX_W;
  localparam int unsigned TBL_W      = N_ENTRIES * CODE_W;
  localparam int unsigned CFG_ADDR_W = 2;
  localparam int unsigned CTRL_EN_BIT = 1;

  // Descriptor bit feeding index bit b (position matters: index order)
  localparam int unsigned IDX_SRC [IDX_W] = '{6, 51, 53, 54};

  localparam logic [CFG_ADDR_W-1:0] A_UNPRIV = 2'd0;
  localparam logic [CFG_ADDR_W-1:0] A_PRIV   = 2'd1;
  localparam logic [CFG_ADDR_W-1:0] A_CTRL   = 2'd2;

  typedef struct packed {
    logic bypass;
    logic reserved;
    logic gcs;
    logic overlay;
    logic x;
    logic w;
    logic r;
  } perm_res_t;
endpackage

// File: rtl/pi_table_regs.sv
module pi_table_regs
  import perm_indir_pkg::*;
#(
  parameter int unsigned TW = TBL_W,
  parameter int unsigned AW = CFG_ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  output logic [TW-1:0] tbl_unpriv,
  output logic [TW-1:0] tbl_priv,
  output logic          ind_en
);
  logic [TW-1:0] unpriv_d, unpriv_q, priv_d, priv_q;
  logic          en_d, en_q;

  always_comb begin
    unpriv_d = unpriv_q;
    priv_d   = priv_q;
    en_d     = en_q;
    if (cfg_we) begin
      case (cfg_addr)
        A_UNPRIV: unpriv_d = cfg_wdata;
        A_PRIV:   priv_d   = cfg_wdata;
        A_CTRL:   en_d     = cfg_wdata[CTRL_EN_BIT];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unpriv_q <= '0;
      priv_q   <= '0;
      en_q     <= 1'b0;
    end else if (cfg_we) begin
      unpriv_q <= unpriv_d;
      priv_q   <= priv_d;
      en_q     <= en_d;
    end
  end

  assign tbl_unpriv = unpriv_q;
  assign tbl_priv   = priv_q;
  assign ind_en     = en_q;
endmodule

// File: rtl/pi_index_extract.sv
module pi_index_extract
  import perm_indir_pkg::*;
#(
  parameter int unsigned DW = DESC_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic [DW-1:0] desc,
  output logic [IW-1:0] idx
);
  for (genvar b = 0; b < IW; b++) begin : g_bit
    assign idx[b] = desc[IDX_SRC[b]];
  end
endmodule

// File: rtl/pi_code_decode.sv
module pi_code_decode
  import perm_indir_pkg::*;
#(
  parameter int unsigned CW = CODE_W
) (
  input  logic [CW-1:0] code,
  input  logic          en,
  output perm_res_t     res
);
  always_comb begin
    res = '0;
    if (!en) begin
      res.bypass = 1'b1;
    end else begin
      case (code)
        4'h0: res.overlay = 1'b1;
        4'h1: begin res.overlay = 1'b1; res.r = 1'b1; end
        4'h2: begin res.overlay = 1'b1; res.x = 1'b1; end
        4'h3: begin res.overlay = 1'b1; res.r = 1'b1; res.x = 1'b1; end
        4'h5: begin res.overlay = 1'b1; res.r = 1'b1; res.w = 1'b1; end
        4'h6: begin res.overlay = 1'b1; res.r = 1'b1; res.w = 1'b1; end
        4'h7: begin res.overlay = 1'b1; res.r = 1'b1; res.w = 1'b1; res.x = 1'b1; end
        4'h8: res.r = 1'b1;
        4'h9: res.gcs = 1'b1;
        4'ha: begin res.r = 1'b1; res.x = 1'b1; end
        4'hc: begin res.r = 1'b1; res.w = 1'b1; end
        4'he: begin res.r = 1'b1; res.w = 1'b1; res.x = 1'b1; end
        default: res.reserved = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/perm_indir_unit.sv
module perm_indir_unit
  import perm_indir_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [TBL_W-1:0]      cfg_wdata,
  input  logic                  req_valid,
  input  logic [DESC_W-1:0]     req_desc,
  input  logic                  req_priv,
  output logic                  rsp_valid,
  output logic                  rsp_read,
  output logic                  rsp_write,
  output logic                  rsp_exec,
  output logic                  rsp_overlay,
  output logic                  rsp_gcs,
  output logic                  rsp_reserved,
  output logic                  rsp_bypass
);
  logic [TBL_W-1:0]  tbl_unpriv, tbl_priv, tbl_sel;
  logic              ind_en;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] code;
  perm_res_t         dec, res_d, res_q;
  logic              vld_q;

  pi_table_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .tbl_unpriv (tbl_unpriv),
    .tbl_priv   (tbl_priv),
    .ind_en     (ind_en)
  );

  pi_index_extract u_idx (
    .desc (req_desc),
    .idx  (idx)
  );

  assign tbl_sel = req_priv ? tbl_priv : tbl_unpriv;
  assign code    = tbl_sel[idx*CODE_W +: CODE_W];

  pi_code_decode u_dec (
    .code (code),
    .en   (ind_en),
    .res  (dec)
  );

  always_comb begin
    res_d = res_q;
    if (req_valid) res_d = dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= req_valid;
      if (req_valid) res_q <= res_d;
    end
  end

  assign rsp_valid    = vld_q;
  assign rsp_read     = res_q.r;
  assign rsp_write    = res_q.w;
  assign rsp_exec     = res_q.x;
  assign rsp_overlay  = res_q.overlay;
  assign rsp_gcs      = res_q.gcs;
  assign rsp_reserved = res_q.reserved;
  assign rsp_bypass   = res_q.bypass;
endmodule

// File: rtl/pi_checker.sv
module pi_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic ind_en,
  input logic cfg_we,
  input logic rsp_valid,
  input logic rsp_read,
  input logic rsp_write,
  input logic rsp_exec,
  input logic rsp_overlay,
  input logic rsp_gcs,
  input logic rsp_reserved,
  input logic rsp_bypass
);
  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable({rsp_read, rsp_write, rsp_exec, rsp_overlay,
                            rsp_gcs, rsp_reserved, rsp_bypass}));
  p_class_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rsp_bypass, rsp_reserved, rsp_gcs, rsp_overlay}) <= 1);
  p_write_has_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_write |-> rsp_read);
  p_gcs_no_rights_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_gcs |-> !(rsp_read || rsp_write || rsp_exec));
  p_reserved_no_rights_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_reserved |-> !(rsp_read || rsp_write || rsp_exec));
  p_disabled_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ind_en && !cfg_we) |=> (rsp_bypass && !rsp_read && !rsp_write && !rsp_exec));
  p_enabled_no_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ind_en && !cfg_we) |=> !rsp_bypass);
endmodule

bind perm_indir_unit pi_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .ind_en       (ind_en),
  .cfg_we       (cfg_we),
  .rsp_valid    (rsp_valid),
  .rsp_read     (rsp_read),
  .rsp_write    (rsp_write),
  .rsp_exec     (rsp_exec),
  .rsp_overlay  (rsp_overlay),
  .rsp_gcs      (rsp_gcs),
  .rsp_reserved (rsp_reserved),
  .rsp_bypass   (rsp_bypass)
);

// File: tb/perm_indir_unit_tb.sv
module perm_indir_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [63:0] req_desc = '0;
  logic        req_priv = 1'b0;
  logic rsp_valid, rsp_read, rsp_write, rsp_exec;
  logic rsp_overlay, rsp_gcs, rsp_reserved, rsp_bypass;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  logic [63:0] m_unpriv = '0, m_priv = '0;
  logic        m_en = 1'b0;
  logic [6:0]  q_exp [$];
  string       q_tag [$];
  logic [6:0]  last_seen = '0;

  always #2 clk = ~clk;

  perm_indir_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_desc(req_desc),
    .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_read(rsp_read),
    .rsp_write(rsp_write), .rsp_exec(rsp_exec), .rsp_overlay(rsp_overlay),
    .rsp_gcs(rsp_gcs), .rsp_reserved(rsp_reserved), .rsp_bypass(rsp_bypass)
  );

  function automatic logic [6:0] outs();
    return {rsp_bypass, rsp_reserved, rsp_gcs, rsp_overlay, rsp_exec, rsp_write, rsp_read};
  endfunction

  // {bypass, reserved, gcs, overlay, x, w, r}
  function automatic logic [6:0] exp_of(logic [3:0] c, logic en);
    if (!en) return 7'b1000000;
    case (c)
      4'h0: return 7'b0001000;
      4'h1: return 7'b0001001;
      4'h2: return 7'b0001100;
      4'h3: return 7'b0001101;
      4'h5, 4'h6: return 7'b0001011;
      4'h7: return 7'b0001111;
      4'h8: return 7'b0000001;
      4'h9: return 7'b0010000;
      4'ha: return 7'b0000101;
      4'hc: return 7'b0000011;
      4'he: return 7'b0000111;
      default: return 7'b0100000;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'h8, 4'ha, 4'hc, 4'he: return "R4";
      4'h9: return "R5";
      4'h4, 4'hb, 4'hd, 4'hf: return "R7";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [63:0] mk_desc(logic [3:0] ix, bit noise);
    logic [63:0] d;
    d = noise ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0;
    d[54] = ix[3]; d[53] = ix[2]; d[51] = ix[1]; d[6] = ix[0];
    return d;
  endfunction

  task automatic cyc(input bit we, input logic [1:0] a, input logic [63:0] wd,
                     input bit rv, input logic [63:0] desc, input bit priv,
                     input string tag);
    logic [3:0]  ix;
    logic [63:0] t;
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    req_valid = rv; req_desc = desc; req_priv = priv;
    if (rv) begin
      ix = {desc[54], desc[53], desc[51], desc[6]};
      t  = priv ? m_priv : m_unpriv;
      q_exp.push_back(exp_of(t[ix*4 +: 4], m_en));
      q_tag.push_back(tag);
    end
    if (we) begin
      case (a)
        2'd0: m_unpriv = wd;
        2'd1: m_priv = wd;
        2'd2: m_en = wd[1];
        default: ;
      endcase
    end
  endtask

  task automatic idle();
    cyc(0, 2'd0, 64'h0, 0, 64'h0, 0, "");
  endtask

  task automatic lookup(input logic [63:0] d, input bit p, input string tag);
    cyc(0, 2'd0, 64'h0, 1, d, p, tag);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor / scoreboard
  initial begin
    logic [6:0] e;
    string tg;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && rsp_valid) begin
        if (q_exp.size() == 0) begin
          check(0, "R10 unexpected response", 64'(outs()), 64'h0);
        end else begin
          e  = q_exp.pop_front();
          tg = q_tag.pop_front();
          check(outs() === e, tg, 64'(outs()), 64'(e));
          last_seen = e;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && outs() == 7'b0, "R1 reset outputs", 64'({rsp_valid, outs()}), 64'h0);
    rst_n = 1'b1;
    idle();
    // R1: disabled after reset
    lookup(mk_desc(4'h5, 0), 0, "R1 bypass after reset");
    idle();
    cyc(1, 2'd2, 64'h2, 0, 64'h0, 0, "");
    lookup(mk_desc(4'h3, 0), 0, "R1 zero table");
    lookup(mk_desc(4'hc, 0), 1, "R1 zero table priv");
    // R3: program tables, unpriv field N = N, priv field N = 15-N
    cyc(1, 2'd0, 64'hFEDC_BA98_7654_3210, 0, 64'h0, 0, "");
    cyc(1, 2'd1, 64'h0123_4567_89AB_CDEF, 0, 64'h0, 0, "");
    for (int i = 0; i < 16; i++) begin
      lookup(mk_desc(4'(i), 0), 0, $sformatf("R3/%s unpriv idx %0d", tag_of(4'(i)), i));
      lookup(mk_desc(4'(i), 0), 1, $sformatf("R3/%s priv idx %0d", tag_of(4'(15 - i)), i));
    end
    // R2: other descriptor bits set must not matter
    for (int i = 0; i < 16; i += 5)
      lookup(mk_desc(4'(i), 1), 0, $sformatf("R2 noise idx %0d", i));
    lookup(64'h0040_0000_0000_0000, 0, "R2 bit54 only");
    lookup(64'h0000_0000_0000_0040, 0, "R2 bit6 only");
    // R9: same-cycle write and lookup sees old contents
    cyc(1, 2'd0, 64'h8888_8888_8888_8888, 1, mk_desc(4'he, 0), 0, "R9 old value");
    lookup(mk_desc(4'he, 0), 0, "R9 new value");
    // R11: address 3 ignored
    cyc(1, 2'd3, 64'h0, 0, 64'h0, 0, "");
    lookup(mk_desc(4'h7, 0), 1, "R11 priv kept after addr3");
    lookup(mk_desc(4'h2, 0), 0, "R11 unpriv kept after addr3");
    // R8: disable with other control bits set
    cyc(1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFD, 0, 64'h0, 0, "");
    lookup(mk_desc(4'h1, 0), 1, "R8 disabled priv");
    lookup(mk_desc(4'h9, 0), 0, "R8 disabled unpriv");
    cyc(1, 2'd2, 64'h2, 0, 64'h0, 0, "");
    lookup(mk_desc(4'h1, 0), 1, "R8 re-enabled");
    // R10: idle holds, no valid
    idle(); idle(); idle();
    @(posedge clk); #1;
    check(rsp_valid == 1'b0, "R10 valid low when idle", 64'(rsp_valid), 64'h0);
    check(outs() === last_seen, "R10 outputs held", 64'(outs()), 64'(last_seen));
    check(q_exp.size() == 0, "R10 all responses seen", 64'(q_exp.size()), 64'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule